// File: doc/BRIEF.md
# Pause-Spaced Downlink Frame Decoder

This block recovers the reader-to-tag command stream from a single demodulated line on which the carrier is interrupted by short pauses. A pause pulls the line low; the time from the start of one pause to the start of the next gives the value of one bit. The line is sampled against a 212 kHz tick enable, so every time quantity below is a number of tick-enable cycles.

The decoder waits for the first pause, times each gap between pause starts, and removes a keystream by XOR with a bit supplied from outside. It requests the next keystream bit with a one-cycle strobe. The frame carries no length field. A frame therefore ends on the first code violation, which is normally the missing pause after the last bit. The block then reports the word, its bit count and a timestamp for the end of the frame, or it reports an error. While it waits for a frame it keeps the keystream moving at the tag bit rate and gives up after a long silence.

Top module: `pause_frame_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `frame_valid`, `err`, `ks_adv`, `frame_len`, `frame_data` and `frame_stamp` are all zero.
- R2: In the bit-receive state, a falling line edge that arrives N ticks after the previous falling edge, with 4 ≤ N ≤ 31, is accepted as a bit. The bit is 1 when N > 17 and 0 when N ≤ 17 (so 17 gives 0, and 18 and 31 give 1).
- R3: Each accepted bit is XORed with `ks_bit` as sampled on the accepting tick and stored at bit position k of the word, where k is the number of bits already accepted. `ks_adv` pulses for one cycle, one clock after that tick. No keystream advance is requested on the tick that ends a frame or reports a length error.
- R4: A falling edge that arrives fewer than 4 ticks after the previous one is a code violation and ends the frame. The short bit is not counted.
- R5: If no falling edge arrives within 31 ticks of the last one, the tick on which the count reaches 32 is a code violation and ends the frame.
- R6: A frame that ends with between 6 and 23 accepted bits gives a one-cycle `frame_valid` pulse, one clock after the violating tick. At the same time `frame_len` takes the bit count and `frame_data` takes the word (bit 0 first, upper bits zero).
- R7: A frame that ends with fewer than 6 or more than 23 accepted bits gives a one-cycle `err` pulse with `err_timeout` = 0 and no `frame_valid`.
- R8: While waiting for a frame start, `ks_adv` pulses once every 21 ticks, counted from reset or from the tick that ended the previous frame or error.
- R9: When the 401st such idle period completes without a frame start, `err` pulses with `err_timeout` = 1. This is exactly 401 × 21 ticks after the tick that ended the last frame, and waiting then starts again.
- R10: `frame_stamp` equals the tick-counter value at the last accepted falling edge plus 2. The tick counter starts at zero on reset and counts every tick.
- R11: `line_in` passes through two flops and is examined only on tick cycles. A low level that lasts one clock and lies entirely between tick samples starts no frame.
- R12: `frame_len` and `frame_data` change only on cycles where `frame_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 212 kHz sampling enable, one clock wide |
| line_in | input | 1 | Demodulated downlink level, low during a pause (asynchronous) |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle request to advance the keystream |
| frame_valid | output | 1 | One-cycle pulse: a frame was received |
| frame_len | output | 5 | Bit count of the last good frame |
| frame_data | output | 23 | Descrambled word of the last good frame, bit 0 first |
| frame_stamp | output | 16 | Frame-end timestamp in ticks |
| err | output | 1 | One-cycle pulse: length error or idle timeout |
| err_timeout | output | 1 | Error cause, valid with `err`: 1 = idle timeout, 0 = bad length |

## Verification
Directed frames use the nominal 13- and 21-tick gaps with a constant keystream of 0 and then of 1, which separates bit classification from descrambling. A boundary frame places gaps of 4, 17, 18 and 31 ticks on both sides of each threshold. Further frames end on a short gap, stop at 5, 23 and 24 bits, and use random lengths with a shifting keystream. Together these tell a normal end apart from a length error and show that the outputs hold across an error. A single-clock glitch between ticks and a long idle stretch check the synchronizer and the exact timeout point, and the idle stretch also counts the keystream strobes. A behavioural model in the bench predicts every output on every clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_BITS = 1'b1
    } pfd_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_BIT  = 2'd1,
        EV_VIOL = 2'd2
    } pfd_event_e;

    typedef struct packed {
        pfd_event_e kind;
        logic       value;
    } pfd_bit_s;

    // decision point halfway between the two nominal bit lengths
    function automatic int split_point(input int short_len, input int long_len);
        return (short_len + long_len) / 2;
    endfunction

    // longest accepted gap: one and a half long bits
    function automatic int grace_limit(input int long_len);
        return (long_len * 3) / 2;
    endfunction

    // width needed to hold values 0..n
    function automatic int bits_for(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pfd_line_sync.sv
module pfd_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_in,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    // idle line carries the carrier (high), so all stages reset high
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q <= line_in;
            s2_q <= s1_q;
            if (tick) prev_q <= s2_q;
        end
    end

    assign fall = tick & prev_q & ~s2_q;

endmodule

// File: rtl/pfd_bit_timer.sv
module pfd_bit_timer
    import pfd_pkg::*;
#(
    parameter int TICK_PAUSE = 4,
    parameter int TICK_ZERO  = 13,
    parameter int TICK_ONE   = 21
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     fall,
    input  logic     active,
    output pfd_bit_s bit_o
);
    localparam int THRESH = split_point(TICK_ZERO, TICK_ONE);
    localparam int LIMIT  = grace_limit(TICK_ONE);
    localparam int EL_W   = bits_for(LIMIT + 1);
    localparam logic [EL_W-1:0] EL_SAT    = EL_W'(LIMIT + 1);
    localparam logic [EL_W-1:0] EL_LIMIT  = EL_W'(LIMIT);
    localparam logic [EL_W-1:0] EL_THRESH = EL_W'(THRESH);
    localparam logic [EL_W-1:0] EL_PAUSE  = EL_W'(TICK_PAUSE);

    logic [EL_W-1:0] el_q;
    logic [EL_W-1:0] el_now;

    // ticks since the last falling edge, including the current tick
    assign el_now = (el_q == EL_SAT) ? el_q : el_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            el_q <= '0;
        end else if (tick) begin
            el_q <= fall ? '0 : el_now;
        end
    end

    always_comb begin
        bit_o.kind  = EV_NONE;
        bit_o.value = (el_now > EL_THRESH);
        if (active && tick) begin
            if ((el_now > EL_LIMIT) || (fall && (el_now < EL_PAUSE))) begin
                bit_o.kind = EV_VIOL;
            end else if (fall) begin
                bit_o.kind = EV_BIT;
            end
        end
    end

endmodule

// File: rtl/pfd_frame_ctrl.sv
module pfd_frame_ctrl
    import pfd_pkg::*;
#(
    parameter int TICK_ONE     = 21,
    parameter int MIN_LEN      = 6,
    parameter int MAX_LEN      = 23,
    parameter int IDLE_PERIODS = 400,
    parameter int STAMP_W      = 16,
    parameter int STAMP_ADJ    = 2,
    parameter int LEN_W        = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               fall,
    input  logic               ks_bit,
    input  pfd_bit_s           bit_i,
    output logic               active,
    output logic               ks_adv,
    output logic               frame_valid,
    output logic [LEN_W-1:0]   frame_len,
    output logic [MAX_LEN-1:0] frame_data,
    output logic [STAMP_W-1:0] frame_stamp,
    output logic               err,
    output logic               err_timeout
);
    localparam int PC_W  = bits_for(TICK_ONE - 1);
    localparam int PER_W = bits_for(IDLE_PERIODS);
    localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(TICK_ONE - 1);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(IDLE_PERIODS);
    localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_SAT  = '1;
    localparam logic [STAMP_W-1:0] ADJ    = STAMP_W'(STAMP_ADJ);

    pfd_state_e         state_q;
    logic [PC_W-1:0]    pc_q;
    logic [PER_W-1:0]   per_q;
    logic [LEN_W-1:0]   len_q;
    logic [MAX_LEN-1:0] acc_q;
    logic [STAMP_W-1:0] now_q;
    logic [STAMP_W-1:0] last_q;
    logic               len_ok;
    logic               clean_bit;

    assign active    = (state_q == ST_BITS);
    assign len_ok    = (len_q >= LEN_MIN) && (len_q <= LEN_MAX);
    assign clean_bit = bit_i.value ^ ks_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HUNT;
            pc_q        <= '0;
            per_q       <= '0;
            len_q       <= '0;
            acc_q       <= '0;
            now_q       <= '0;
            last_q      <= '0;
            ks_adv      <= 1'b0;
            frame_valid <= 1'b0;
            frame_len   <= '0;
            frame_data  <= '0;
            frame_stamp <= '0;
            err         <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            ks_adv      <= 1'b0;
            frame_valid <= 1'b0;
            err         <= 1'b0;
            if (tick) begin
                now_q <= now_q + 1'b1;
                unique case (state_q)
                    ST_HUNT: begin
                        if (fall) begin
                            state_q <= ST_BITS;
                            len_q   <= '0;
                            acc_q   <= '0;
                            last_q  <= now_q;
                        end else if (pc_q == PC_LAST) begin
                            pc_q   <= '0;
                            ks_adv <= 1'b1;
                            if (per_q == PER_LAST) begin
                                per_q       <= '0;
                                err         <= 1'b1;
                                err_timeout <= 1'b1;
                            end else begin
                                per_q <= per_q + 1'b1;
                            end
                        end else begin
                            pc_q <= pc_q + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        case (bit_i.kind)
                            EV_VIOL: begin
                                state_q <= ST_HUNT;
                                pc_q    <= '0;
                                per_q   <= '0;
                                if (len_ok) begin
                                    frame_valid <= 1'b1;
                                    frame_len   <= len_q;
                                    frame_data  <= acc_q;
                                    frame_stamp <= last_q + ADJ;
                                end else begin
                                    err         <= 1'b1;
                                    err_timeout <= 1'b0;
                                end
                            end
                            EV_BIT: begin
                                if (len_q < LEN_MAX) begin
                                    acc_q <= acc_q | (MAX_LEN'(clean_bit) << len_q);
                                end
                                if (len_q != LEN_SAT) len_q <= len_q + 1'b1;
                                ks_adv <= 1'b1;
                                last_q <= now_q;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pause_frame_decoder.sv
module pause_frame_decoder
    import pfd_pkg::*;
#(
    parameter  int TICK_PAUSE   = 4,
    parameter  int TICK_ZERO    = 13,
    parameter  int TICK_ONE     = 21,
    parameter  int MIN_LEN      = 6,
    parameter  int MAX_LEN      = 23,
    parameter  int IDLE_PERIODS = 400,
    parameter  int STAMP_W      = 16,
    parameter  int PIPE_DELAY   = 2,
    localparam int LEN_W        = bits_for(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               line_in,
    input  logic               ks_bit,
    output logic               ks_adv,
    output logic               frame_valid,
    output logic [LEN_W-1:0]   frame_len,
    output logic [MAX_LEN-1:0] frame_data,
    output logic [STAMP_W-1:0] frame_stamp,
    output logic               err,
    output logic               err_timeout
);
    localparam int STAMP_ADJ = TICK_PAUSE - PIPE_DELAY;

    logic     fall;
    logic     active;
    pfd_bit_s bit_ev;

    pfd_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .line_in(line_in),
        .fall   (fall)
    );

    pfd_bit_timer #(
        .TICK_PAUSE(TICK_PAUSE),
        .TICK_ZERO (TICK_ZERO),
        .TICK_ONE  (TICK_ONE)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .fall  (fall),
        .active(active),
        .bit_o (bit_ev)
    );

    pfd_frame_ctrl #(
        .TICK_ONE    (TICK_ONE),
        .MIN_LEN     (MIN_LEN),
        .MAX_LEN     (MAX_LEN),
        .IDLE_PERIODS(IDLE_PERIODS),
        .STAMP_W     (STAMP_W),
        .STAMP_ADJ   (STAMP_ADJ),
        .LEN_W       (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fall       (fall),
        .ks_bit     (ks_bit),
        .bit_i      (bit_ev),
        .active     (active),
        .ks_adv     (ks_adv),
        .frame_valid(frame_valid),
        .frame_len  (frame_len),
        .frame_data (frame_data),
        .frame_stamp(frame_stamp),
        .err        (err),
        .err_timeout(err_timeout)
    );

endmodule

// File: rtl/pause_frame_decoder_chk.sv
module pause_frame_decoder_chk #(
    parameter int MIN_LEN = 6,
    parameter int MAX_LEN = 23,
    parameter int LEN_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               ks_adv,
    input logic               frame_valid,
    input logic [LEN_W-1:0]   frame_len,
    input logic [MAX_LEN-1:0] frame_data,
    input logic               err,
    input logic               err_timeout
);
    localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_len_window_r6: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (frame_len >= LO) && (frame_len <= HI));

    p_valid_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && err));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_adv_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        ks_adv |-> $past(tick));

    p_no_adv_at_end_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid || (err && !err_timeout)) |-> !ks_adv);

    p_report_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> ($stable(frame_len) && $stable(frame_data)));

endmodule

bind pause_frame_decoder pause_frame_decoder_chk #(
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .ks_adv     (ks_adv),
    .frame_valid(frame_valid),
    .frame_len  (frame_len),
    .frame_data (frame_data),
    .err        (err),
    .err_timeout(err_timeout)
);

// File: tb/pause_frame_decoder_test.sv
module pause_frame_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        line_in = 1'b1;
    logic        ks_bit = 1'b0;
    logic        ks_adv;
    logic        frame_valid;
    logic [4:0]  frame_len;
    logic [22:0] frame_data;
    logic [15:0] frame_stamp;
    logic        err;
    logic        err_timeout;

    always #4 clk = ~clk;

    pause_frame_decoder uut (
        .clk(clk), .rst(rst), .tick(tick), .line_in(line_in), .ks_bit(ks_bit),
        .ks_adv(ks_adv), .frame_valid(frame_valid), .frame_len(frame_len),
        .frame_data(frame_data), .frame_stamp(frame_stamp), .err(err),
        .err_timeout(err_timeout)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit started = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // tick cadence and keystream source
    int         tdiv = 0;
    int         ks_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        if (ks_adv) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick <= (tdiv == 0);
        tdiv <= (tdiv + 1) % 4;
        ks_bit <= (ks_mode == 0) ? 1'b0 : (ks_mode == 1) ? 1'b1 : lfsr[0];
    end

    // behavioural reference model
    logic m_s1, m_s2, m_prev, lvl, fl;
    bit   m_hunt;
    int   m_pc, m_per, m_el, m_len, m_now, m_last, e;
    logic [22:0] m_acc;
    logic e_fv, e_err, e_to, e_adv;
    int   e_len, e_stamp;
    logic [22:0] e_data;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_hunt = 1;
            m_pc = 0; m_per = 0; m_el = 0; m_len = 0; m_acc = '0; m_now = 0; m_last = 0;
            e_fv = 0; e_err = 0; e_to = 0; e_adv = 0; e_len = 0; e_data = '0; e_stamp = 0;
        end else begin
            lvl = m_s2; m_s2 = m_s1; m_s1 = line_in;
            e_fv = 0; e_err = 0; e_adv = 0;
            if (tick) begin
                fl = m_prev && !lvl;
                m_prev = lvl;
                if (m_hunt) begin
                    if (fl) begin
                        m_hunt = 0; m_len = 0; m_acc = '0; m_last = m_now; m_el = 0;
                    end else if (m_pc == 20) begin
                        m_pc = 0; e_adv = 1;
                        if (m_per == 400) begin m_per = 0; e_err = 1; e_to = 1; end
                        else m_per++;
                    end else m_pc++;
                end else begin
                    e = m_el + 1;
                    if (e > 31 || (fl && e < 4)) begin
                        if (m_len >= 6 && m_len <= 23) begin
                            e_fv = 1; e_len = m_len; e_data = m_acc; e_stamp = (m_last + 2) % 65536;
                        end else begin
                            e_err = 1; e_to = 0;
                        end
                        m_hunt = 1; m_pc = 0; m_per = 0;
                    end else if (fl) begin
                        if (m_len < 23 && ((e > 17) ^ ks_bit)) m_acc[m_len] = 1'b1;
                        e_adv = 1;
                        if (m_len < 31) m_len++;
                        m_el = 0; m_last = m_now;
                    end else m_el = e;
                end
                m_now = (m_now + 1) % 65536;
            end
        end
    end

    // per-clock comparison and event capture
    int n_fv = 0, n_err = 0, fv_cyc = 0, err_cyc = 0;
    logic [4:0]  cap_len;
    logic [22:0] cap_data;
    logic        cap_to;
    always @(negedge clk) begin
        cyc++;
        if (started && !rst) begin
            chk(frame_valid == e_fv, "R6", "frame_valid", frame_valid, e_fv);
            chk(err == e_err, "R7", "err", err, e_err);
            if (e_err) chk(err_timeout == e_to, "R9", "err_timeout", err_timeout, e_to);
            chk(ks_adv == e_adv, "R8", "ks_adv", ks_adv, e_adv);
            chk(frame_len == 5'(e_len), "R12", "frame_len", frame_len, e_len);
            chk(frame_data == e_data, "R3", "frame_data", frame_data, e_data);
            chk(frame_stamp == 16'(e_stamp), "R10", "frame_stamp", frame_stamp, e_stamp);
        end
        if (frame_valid) begin n_fv++; cap_len = frame_len; cap_data = frame_data; fv_cyc = cyc; end
        if (err) begin n_err++; cap_to = err_timeout; err_cyc = cyc; end
        if (cyc > 190000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // stimulus helpers
    int sp [0:31];
    task automatic seg(input logic lv, input int n);
        line_in = lv;
        repeat (n * 4) @(negedge clk);
    endtask
    task automatic send_sp(input int s);
        if (s >= 5) begin seg(1'b0, 4); seg(1'b1, s - 4); end
        else begin seg(1'b0, s - 1); seg(1'b1, 1); end
    endtask
    task automatic send_frame(input int n);
        seg(1'b1, 10);
        for (int i = 0; i < n; i++) send_sp(sp[i]);
        seg(1'b0, 4);
        seg(1'b1, 45);
    endtask
    task automatic load_bits(input logic [31:0] b, input int n);
        for (int i = 0; i < n; i++) sp[i] = b[i] ? 21 : 13;
    endtask
    task automatic expect_frame(input string req, input int f0, input int len, input logic [22:0] dat);
        chk(n_fv == f0 + 1, req, "frame count", n_fv, f0 + 1);
        chk(cap_len == 5'(len), req, "length", cap_len, len);
        chk(cap_data == dat, req, "data", cap_data, dat);
    endtask

    int f0, r0, n, cnt, guard;
    logic [31:0] rb;
    logic [22:0] mask;

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!frame_valid && !err && !ks_adv, "R1", "pulses in reset", {frame_valid, err, ks_adv}, 0);
        chk(frame_len == 0 && frame_data == 0 && frame_stamp == 0, "R1", "report in reset",
            frame_data, 0);
        @(negedge clk);
        rst = 1'b0;
        started = 1;
        @(negedge clk); #1;
        chk(!frame_valid && !err && frame_len == 0, "R1", "after reset", {frame_valid, err}, 0);

        // R2: nominal gaps, keystream zero
        f0 = n_fv; load_bits(32'hB2, 8); send_frame(8);
        expect_frame("R2", f0, 8, 23'hB2);

        // R3: constant keystream one inverts every bit
        ks_mode = 1;
        f0 = n_fv; load_bits(32'hB2, 8); send_frame(8);
        expect_frame("R3", f0, 8, 23'h4D);
        ks_mode = 0;

        // R2/R5: threshold corners 17,18,31,4 plus nominal gaps
        sp[0] = 17; sp[1] = 18; sp[2] = 31; sp[3] = 4; sp[4] = 13; sp[5] = 21;
        f0 = n_fv; send_frame(6);
        expect_frame("R5", f0, 6, 23'h26);

        // R4: short gap ends frame after seven bits
        load_bits(32'h55, 7); sp[7] = 3;
        f0 = n_fv; send_frame(8);
        expect_frame("R4", f0, 7, 23'h55);

        // R7/R12: five bits is too short; report holds
        f0 = n_fv; r0 = n_err; load_bits(32'h15, 5); send_frame(5);
        chk(n_err == r0 + 1, "R7", "short frame error", n_err, r0 + 1);
        chk(cap_to == 1'b0, "R7", "error cause", cap_to, 0);
        chk(n_fv == f0, "R7", "no frame report", n_fv, f0);
        chk(frame_len == 5'd7 && frame_data == 23'h55, "R12", "held report", frame_data, 23'h55);

        // R6: longest legal frame
        f0 = n_fv; load_bits(32'h5A5A5A, 23); send_frame(23);
        expect_frame("R6", f0, 23, 23'h5A5A5A);

        // R7: one bit too many
        f0 = n_fv; r0 = n_err; load_bits(32'hA5A5A5, 24); send_frame(24);
        chk(n_err == r0 + 1 && cap_to == 1'b0, "R7", "long frame error", n_err, r0 + 1);
        chk(frame_data == 23'h5A5A5A && frame_len == 5'd23, "R12", "held after long", frame_data, 23'h5A5A5A);

        // random frames with a shifting keystream (R3, R6, R10 via model)
        ks_mode = 2;
        for (int k = 0; k < 20; k++) begin
            n = 6 + int'($urandom % 18);
            rb = $urandom;
            load_bits(rb, n);
            f0 = n_fv;
            send_frame(n);
            chk(n_fv == f0 + 1 && cap_len == 5'(n), "R6", "random frame length", cap_len, n);
        end

        // R11: one-clock low between tick samples is ignored
        f0 = n_fv; r0 = n_err;
        @(negedge clk); #1;
        while (!tick) begin @(negedge clk); #1; end
        line_in = 1'b0;
        @(negedge clk);
        line_in = 1'b1;
        repeat (160) @(negedge clk);
        #1;
        chk(n_err == r0 && n_fv == f0, "R11", "glitch events", n_err - r0 + n_fv - f0, 0);

        // R9: idle timeout exactly 401 periods after last frame end
        r0 = n_err; guard = 0;
        while (n_err == r0 && guard < 40000) begin @(negedge clk); #1; guard++; end
        chk(n_err == r0 + 1, "R9", "timeout seen", n_err, r0 + 1);
        chk(cap_to == 1'b1, "R9", "timeout cause", cap_to, 1);
        chk(err_cyc - fv_cyc == 401 * 21 * 4, "R9", "timeout distance", err_cyc - fv_cyc, 401 * 21 * 4);

        // R8: ten idle strobes in the next 210 ticks
        cnt = int'(ks_adv);
        repeat (837) begin @(negedge clk); #1; cnt += int'(ks_adv); end
        chk(cnt == 10, "R8", "idle strobes", cnt, 10);

        repeat (8) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule